// File: doc/BRIEF.md
# NAND Command/Address Latch Write Generator

This block produces one write-latch cycle toward an asynchronous NAND flash device. Each cycle carries either a command byte or an address byte. A requester presents a byte with a kind selector. The block raises the matching latch strobe, places the byte on the I/O bus, drives a low pulse on the active-low write strobe, holds everything past the strobe's rising edge, and then waits out the recovery time. When the recovery time ends it reports completion.

All timing windows are given as picosecond parameters. Each is converted to whole clock cycles by rounding up against the clock period (2.5 ns by default), so every strobe edge falls on a counted clock edge. An address cycle has a longer recovery than a command cycle, because a gap is required between the last address byte and any following data write.

Top module: `nand_latch_writer`

## Requirements
- R1: Out of reset and whenever no cycle is in progress, the outputs are cle=0, ale=0, we_n=1, dq_oe=0, dq_out=0, done=0 and req_ready=1.
- R2: A request with req_is_addr=0 is a command cycle and raises cle only. A request with req_is_addr=1 is an address cycle and raises ale only. cle and ale are never high together.
- R3: we_n goes low for exactly ceil(10 ns / 2.5 ns) = 4 cycles. The pulse starts after one setup cycle, in which the latch strobe and the data are already driven.
- R4: The latch strobe and dq_oe stay high for ceil(5 ns / 2.5 ns) = 2 cycles after we_n returns high. Together with R3, this gives 5 cycles of latch and data setup before the rising edge, which is at least the 4 required.
- R5: While dq_oe is 1, dq_out equals the accepted request byte. dq_oe is 1 exactly in the cycles where the latch strobe is high.
- R6: A command cycle is busy for 8 cycles after acceptance, which meets the 20 ns write cycle. done is high in the 8th cycle only.
- R7: An address cycle keeps done low until 28 cycles, ceil(70 ns / 2.5 ns), have passed from the first cycle with we_n high after the pulse. done is high in that 28th cycle, which is the 33rd cycle after acceptance.
- R8: done is a one-cycle pulse, and req_ready is 0 from the cycle after acceptance through the done cycle. A request presented while req_ready is 0 is ignored and leaves the running cycle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when req_ready is 1 |
| req_is_addr | input | 1 | 0 = command byte, 1 = address byte |
| req_byte | input | 8 | Byte to latch |
| req_ready | output | 1 | Block is idle and will accept a request |
| done | output | 1 | One-cycle pulse at the end of recovery |
| cle | output | 1 | Command latch enable toward the device |
| ale | output | 1 | Address latch enable toward the device |
| we_n | output | 1 | Active-low write strobe |
| dq_out | output | 8 | I/O bus value |
| dq_oe | output | 1 | I/O bus driver enable |

## Verification
A wrong phase or counter value shows up on the device pins in the same cycle it arises. It appears as a write pulse of the wrong length, or as a latch strobe or bus enable that drops before the strobe rises. A wrong kind bit inverts cle and ale at once. It can also shorten an address recovery, which moves done and req_ready by 25 cycles. The bench compares every pin on every cycle against a model, so any such fault is reported in the first cycle it disturbs.

// File: rtl/nlw_pkg.sv
// Package: shared phase type and timing helpers for the NAND latch writer.
// Assumes all times are given in picoseconds as positive integers.
package nlw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_PULSE = 3'd2,
        PH_HOLD  = 3'd3,
        PH_RECOV = 3'd4
    } phase_e;

    // Round a picosecond window up to whole clock cycles.
    function automatic int ps_to_cyc(input int win_ps, input int clk_ps);
        return (win_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nlw_seq.sv
// Module: phase sequencer. Walks IDLE -> SETUP -> PULSE -> HOLD -> RECOV -> IDLE,
// spending a parameterised number of cycles in each phase.
// Assumes every length parameter is at least 1 and fits in CW bits.
module nlw_seq
    import nlw_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 2,
    parameter int RCMD_CYC  = 1,
    parameter int RADR_CYC  = 26,
    parameter int CW        = 5
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   req_is_addr,
    output phase_e phase_q,
    output phase_e phase_nxt,
    output logic   accept,
    output logic   done,
    output logic   ready
);

    localparam logic [CW-1:0] LD_SETUP = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] LD_PULSE = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] LD_HOLD  = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] LD_RCMD  = CW'(RCMD_CYC - 1);
    localparam logic [CW-1:0] LD_RADR  = CW'(RADR_CYC - 1);

    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          addr_q;

    assign ready  = (phase_q == PH_IDLE);
    assign accept = ready && req_valid;
    assign done   = (phase_q == PH_RECOV) && (cnt_q == '0);

    // Next phase and remaining-cycle count.
    always_comb begin
        phase_nxt = phase_q;
        cnt_nxt   = cnt_q;
        if (phase_q == PH_IDLE) begin
            if (accept) begin
                phase_nxt = PH_SETUP;
                cnt_nxt   = LD_SETUP;
            end
        end else if (cnt_q != '0) begin
            cnt_nxt = cnt_q - 1'b1;
        end else begin
            case (phase_q)
                PH_SETUP: begin phase_nxt = PH_PULSE; cnt_nxt = LD_PULSE; end
                PH_PULSE: begin phase_nxt = PH_HOLD;  cnt_nxt = LD_HOLD;  end
                PH_HOLD:  begin
                    phase_nxt = PH_RECOV;
                    cnt_nxt   = addr_q ? LD_RADR : LD_RCMD;
                end
                default:  begin phase_nxt = PH_IDLE;  cnt_nxt = '0;       end
            endcase
        end
    end

    // Phase, counter and cycle-kind registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            addr_q  <= 1'b0;
        end else begin
            phase_q <= phase_nxt;
            cnt_q   <= cnt_nxt;
            if (accept) addr_q <= req_is_addr;
        end
    end

endmodule

// File: rtl/nlw_pins.sv
// Module: pin driver. Registers the device-side strobes and bus from the
// sequencer's next phase, so pins change together with the phase register
// and never glitch. Assumes phase_nxt and accept come from nlw_seq.
module nlw_pins
    import nlw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          req_is_addr,
    input  logic [DW-1:0] req_byte,
    input  phase_e        phase_nxt,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          dq_oe,
    output logic [DW-1:0] dq_out
);

    logic          kind_q;
    logic [DW-1:0] byte_q;
    logic          kind_sel;
    logic [DW-1:0] byte_sel;
    logic          active;

    // Use the fresh request in the accept cycle, the stored one afterwards.
    always_comb begin
        kind_sel = accept ? req_is_addr : kind_q;
        byte_sel = accept ? req_byte : byte_q;
        active   = (phase_nxt == PH_SETUP) || (phase_nxt == PH_PULSE) ||
                   (phase_nxt == PH_HOLD);
    end

    // Hold the accepted byte and kind for the duration of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= 1'b0;
            byte_q <= '0;
        end else if (accept) begin
            kind_q <= req_is_addr;
            byte_q <= req_byte;
        end
    end

    // Registered device pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cle    <= 1'b0;
            ale    <= 1'b0;
            we_n   <= 1'b1;
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            cle    <= active && !kind_sel;
            ale    <= active && kind_sel;
            we_n   <= (phase_nxt != PH_PULSE);
            dq_oe  <= active;
            dq_out <= active ? byte_sel : '0;
        end
    end

endmodule

// File: rtl/nand_latch_writer.sv
// Module: top of the NAND command/address latch writer. Converts picosecond
// windows into cycle counts (rounded up) and joins the sequencer and the pin
// driver. Assumes a free-running clock of period CLK_PS.
module nand_latch_writer
    import nlw_pkg::*;
#(
    parameter int DW        = 8,
    parameter int CLK_PS    = 2500,
    parameter int T_CLS_PS  = 10000,
    parameter int T_CLH_PS  = 5000,
    parameter int T_ALS_PS  = 10000,
    parameter int T_ALH_PS  = 5000,
    parameter int T_WP_PS   = 10000,
    parameter int T_WH_PS   = 7500,
    parameter int T_WC_PS   = 20000,
    parameter int T_DS_PS   = 7500,
    parameter int T_DH_PS   = 5000,
    parameter int T_ADL_PS  = 70000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_is_addr,
    input  logic [DW-1:0] req_byte,
    output logic          req_ready,
    output logic          done,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);

    localparam int WP_CYC  = imax(1, ps_to_cyc(T_WP_PS, CLK_PS));
    localparam int SU_NEED = imax(ps_to_cyc(T_DS_PS, CLK_PS),
                                  imax(ps_to_cyc(T_CLS_PS, CLK_PS), ps_to_cyc(T_ALS_PS, CLK_PS)));
    localparam int SU_CYC  = imax(1, SU_NEED - WP_CYC);
    localparam int HD_CYC  = imax(1, imax(ps_to_cyc(T_DH_PS, CLK_PS),
                                  imax(ps_to_cyc(T_CLH_PS, CLK_PS), ps_to_cyc(T_ALH_PS, CLK_PS))));
    localparam int RC_CYC  = imax(1, imax(ps_to_cyc(T_WH_PS, CLK_PS) - HD_CYC,
                                  ps_to_cyc(T_WC_PS, CLK_PS) - SU_CYC - WP_CYC - HD_CYC));
    localparam int RA_CYC  = imax(RC_CYC, ps_to_cyc(T_ADL_PS, CLK_PS) - HD_CYC);
    localparam int MAX_CYC = imax(imax(WP_CYC, SU_CYC), imax(HD_CYC, RA_CYC));
    localparam int CW      = $clog2(MAX_CYC + 1);

    phase_e phase_q;
    phase_e phase_nxt;
    logic   accept;

    nlw_seq #(
        .SETUP_CYC (SU_CYC),
        .PULSE_CYC (WP_CYC),
        .HOLD_CYC  (HD_CYC),
        .RCMD_CYC  (RC_CYC),
        .RADR_CYC  (RA_CYC),
        .CW        (CW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_is_addr (req_is_addr),
        .phase_q     (phase_q),
        .phase_nxt   (phase_nxt),
        .accept      (accept),
        .done        (done),
        .ready       (req_ready)
    );

    nlw_pins #(
        .DW (DW)
    ) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_is_addr (req_is_addr),
        .req_byte    (req_byte),
        .phase_nxt   (phase_nxt),
        .cle         (cle),
        .ale         (ale),
        .we_n        (we_n),
        .dq_oe       (dq_oe),
        .dq_out      (dq_out)
    );

endmodule

// File: rtl/nlw_checker.sv
// Module: property checker for nand_latch_writer, attached by bind.
// Assumes the top's port names and its CLK_PS / T_WP_PS parameters.
module nlw_checker
    import nlw_pkg::*;
#(
    parameter int DW      = 8,
    parameter int CLK_PS  = 2500,
    parameter int T_WP_PS = 10000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_is_addr,
    input logic [DW-1:0] req_byte,
    input logic          req_ready,
    input logic          done,
    input logic          cle,
    input logic          ale,
    input logic          we_n,
    input logic [DW-1:0] dq_out,
    input logic          dq_oe
);

    localparam int WP_CYC = imax(1, ps_to_cyc(T_WP_PS, CLK_PS));

    logic [15:0] low_cnt;

    // Count consecutive cycles with we_n low.
    always_ff @(posedge clk) begin
        if (!rst_n)    low_cnt <= '0;
        else if (!we_n) low_cnt <= low_cnt + 1'b1;
        else           low_cnt <= '0;
    end

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cle && !ale && we_n && !dq_oe));

    // R2
    one_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (low_cnt == 16'(WP_CYC)));

    // R3
    setup_before_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> ((cle || ale) && dq_oe));

    // R4
    hold_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> ((cle || ale) && dq_oe));

    // R5
    bus_with_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (cle || ale));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

endmodule

bind nand_latch_writer nlw_checker #(
    .DW      (DW),
    .CLK_PS  (CLK_PS),
    .T_WP_PS (T_WP_PS)
) u_chk (.*);

// File: tb/sim_nand_latch_writer.sv
// Bench: behavioural per-cycle model (queue of expected pin vectors) compared
// with the design on every falling clock edge.
module sim_nand_latch_writer;

    typedef struct packed {
        logic       cle;
        logic       ale;
        logic       we_n;
        logic       oe;
        logic [7:0] dq;
        logic       done;
        logic       ready;
        logic [2:0] ph;    // 0 idle, 1 setup, 2 pulse, 3 hold, 4 recovery
        logic       addr;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_is_addr = 1'b0;
    logic [7:0] req_byte = 8'h00;
    logic       req_ready, done, cle, ale, we_n, dq_oe;
    logic [7:0] dq_out;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t q[$];
    logic model_ready = 1'b1;

    function automatic int cyc(input int ps);
        return (ps + 2499) / 2500;
    endfunction

    // Phase lengths from the requirements: R3 pulse, R4 hold, R6/R7 totals.
    int n_su = 1;
    int n_wp = cyc(10000);
    int n_hd = cyc(5000);
    int n_rc = cyc(20000) - 1 - cyc(10000) - cyc(5000);
    int n_ra = cyc(70000) - cyc(5000);

    nand_latch_writer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_addr(req_is_addr),
        .req_byte(req_byte), .req_ready(req_ready), .done(done), .cle(cle), .ale(ale),
        .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
        end
    endtask

    function automatic exp_t idle_vec();
        exp_t e;
        e = '0;
        e.we_n = 1'b1;
        e.ready = 1'b1;
        return e;
    endfunction

    // Push the expected per-cycle pin vectors of one accepted request.
    task automatic push_cycle(input logic is_addr, input logic [7:0] b);
        int nrec;
        nrec = is_addr ? n_ra : n_rc;
        for (int i = 1; i <= n_su + n_wp + n_hd + nrec; i++) begin
            exp_t e;
            e = '0;
            e.addr = is_addr;
            if (i <= n_su) e.ph = 3'd1;
            else if (i <= n_su + n_wp) e.ph = 3'd2;
            else if (i <= n_su + n_wp + n_hd) e.ph = 3'd3;
            else e.ph = 3'd4;
            e.we_n = (e.ph != 3'd2);
            e.oe   = (e.ph != 3'd4);
            e.cle  = e.oe && !is_addr;
            e.ale  = e.oe && is_addr;
            e.dq   = e.oe ? b : 8'h00;
            e.done = (i == n_su + n_wp + n_hd + nrec);
            q.push_back(e);
        end
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs.
    task automatic step(input logic v, input logic a, input logic [7:0] b);
        exp_t e;
        string lt;
        @(negedge clk);
        e = (q.size() > 0) ? q.pop_front() : idle_vec();
        if (rst_n) begin
            lt = (e.ph == 3'd0) ? "R1" : (e.ph == 3'd3) ? "R4" : "R2";
            chk(cle == e.cle, lt, "cle", int'(cle), int'(e.cle));
            chk(ale == e.ale, lt, "ale", int'(ale), int'(e.ale));
            chk(we_n == e.we_n, (e.ph == 3'd0) ? "R1" : "R3", "we_n", int'(we_n), int'(e.we_n));
            chk(dq_oe == e.oe, (e.ph == 3'd3) ? "R4" : "R5", "dq_oe", int'(dq_oe), int'(e.oe));
            chk(dq_out == e.dq, "R5", "dq_out", int'(dq_out), int'(e.dq));
            chk(done == e.done, e.addr ? "R7" : "R6", "done", int'(done), int'(e.done));
            chk(req_ready == e.ready, "R8", "req_ready", int'(req_ready), int'(e.ready));
        end
        model_ready = e.ready && rst_n;
        req_valid   = v;
        req_is_addr = a;
        req_byte    = b;
        if (v && model_ready) push_cycle(a, b);
    endtask

    task automatic drain();
        while (q.size() > 0) step(1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        repeat (3) step(1'b0, 1'b0, 8'h00);
        // R1: reset levels, checked explicitly.
        chk(!cle && !ale && we_n && !dq_oe && !done && req_ready && dq_out == 8'h00,
            "R1", "reset idle levels", {cle, ale, we_n, dq_oe, done, req_ready}, 6'b001001);
        rst_n = 1'b1;
        repeat (3) step(1'b0, 1'b0, 8'h00);

        // R2 R3 R4 R5 R6: command cycle.
        step(1'b1, 1'b0, 8'hA5);
        repeat (3) step(1'b0, 1'b0, 8'h00);
        // R8: request while busy is ignored.
        step(1'b1, 1'b1, 8'hFF);
        drain();
        repeat (2) step(1'b0, 1'b0, 8'h00);

        // R7: address cycle with long recovery, plus an ignored request mid-way.
        step(1'b1, 1'b1, 8'h3C);
        repeat (10) step(1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b0, 8'h11);
        while (q.size() > 1) step(1'b0, 1'b0, 8'h00);
        // R8: request in the done cycle is ignored, the next one is taken.
        step(1'b1, 1'b0, 8'h22);
        step(1'b1, 1'b0, 8'h70);
        drain();

        // Back-to-back mixed bytes.
        step(1'b1, 1'b1, 8'h00);
        drain();
        step(1'b1, 1'b0, 8'hFF);
        drain();
        step(1'b1, 1'b1, 8'h81);
        drain();
        repeat (4) step(1'b0, 1'b0, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule